// File: doc/BRIEF.md
# Frame Pulse Tracker with Free-Run

This block keeps the channel timing of a byte-per-clock TDM port aligned to an incoming 8 kHz frame pulse. Each clock is one channel slot. A channel counter runs from zero up to a terminal value, and the rate select picks that value. When the counter wraps, or when it is realigned, the block raises a one-cycle frame-start strobe.

If pulses stop arriving, the counter keeps running on its own frame length, so downstream logic sees steady timing. When a pulse appears, the counter is forced back to channel zero at once. A pulse that lands where the free-running count already expected one is silent. A pulse that lands anywhere else marks a framing change in a sticky error flag, which feeds a maskable interrupt.

A pulse that stays asserted freezes the counter. Once it has stayed asserted for more than one whole frame, the block reports a lock-up.

Top module: `fpt_frame_tracker`

## Requirements
- R1: The rate select sets the terminal channel value: 0 gives 2429, 1 gives 2047, and 2 or 3 give 809. The frame length is the terminal value plus one.
- R2: With no pulse present, the counter advances by one per clock. After the terminal value it wraps to 0 and raises the frame-start strobe for that one cycle.
- R3: The clock edge that first samples the frame pulse active (a leading edge) loads the counter with 0 and raises frame-start in the following cycle, whatever the count was.
- R4: The error flag is set by a leading edge whose count before that edge differs from the terminal value. This does not apply to the first leading edge after reset. An on-time pulse never sets the flag, and neither does a run of missing pulses.
- R5: While the pulse is sampled active on consecutive edges, the counter holds its value and frame-start stays low. Counting resumes at the first edge that samples the pulse inactive.
- R6: The lock-up output rises after the pulse has been sampled active on (frame length + 1) consecutive edges. It falls at the first edge that samples the pulse inactive.
- R7: With the polarity input low, the pulse is active when high. With the polarity input high, it is active when low.
- R8: The error flag stays set until the clear input is sampled high. If a misplaced pulse and a clear arrive on the same edge, the set wins.
- R9: The interrupt output equals the error flag when the mask input is low, and is 0 when the mask input is high.
- R10: During synchronous active-low reset, the count, frame-start, lock-up, error flag and interrupt are all 0.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fp_in | input | 1 | Frame pulse |
| fp_active_low | input | 1 | Frame pulse polarity: 1 means active low |
| rate_sel | input | 2 | Port rate select |
| err_clr | input | 1 | Clears the sticky error flag |
| err_mask | input | 1 | Blocks the interrupt output |
| chan_cnt | output | 12 | Current channel number |
| frame_start | output | 1 | One-cycle strobe when channel 0 begins |
| lockup | output | 1 | Pulse held active for more than one frame |
| err_flag | output | 1 | Sticky framing-change error |
| irq | output | 1 | Masked error interrupt |

## Verification
The assertions expect the frame pulse, polarity, rate select, clear and mask to be synchronous to the clock and steady around each rising edge. They also expect the rate select to change only while the count is at or below the new terminal value, so that the wrap check sees a consistent frame length.

The stimulus drives every input on the falling edge. It changes the rate only in the cycle straight after a realigning pulse, while the count is still near zero. Pulses are one cycle wide, except in the cases that deliberately hold the pulse to exercise the stall and lock-up behaviour.

// File: rtl/fpt_pkg.sv
// Package: shared encodings for the frame pulse tracker.
// Assumes: rate_sel is a plain 2-bit field; code 3 is treated like code 2.
package fpt_pkg;
    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_MID  = 2'd1,
        RATE_SLOW = 2'd2,
        RATE_ALT  = 2'd3
    } rate_e;
endpackage

// File: rtl/fpt_term_sel.sv
// Module: maps the rate select to the terminal channel value of the frame.
// Assumes: every terminal parameter fits in CNT_W bits.
module fpt_term_sel #(
    parameter int CNT_W     = 12,
    parameter int TERM_FAST = 2429,
    parameter int TERM_MID  = 2047,
    parameter int TERM_SLOW = 809
) (
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] term
);
    import fpt_pkg::*;

    localparam logic [CNT_W-1:0] T_FAST = CNT_W'(TERM_FAST);
    localparam logic [CNT_W-1:0] T_MID  = CNT_W'(TERM_MID);
    localparam logic [CNT_W-1:0] T_SLOW = CNT_W'(TERM_SLOW);

    // Decode the rate code into the terminal count (R1).
    always_comb begin
        case (rate_e'(rate_sel))
            RATE_FAST: term = T_FAST;
            RATE_MID:  term = T_MID;
            default:   term = T_SLOW;
        endcase
    end
endmodule

// File: rtl/fpt_pulse_monitor.sv
// Module: normalises the frame pulse polarity and classifies each sample
// as a leading edge or a held level. It also times how long the pulse
// stays active, to flag lock-up.
// Assumes: fp_in is already synchronous to clk.
module fpt_pulse_monitor #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_in,
    input  logic             fp_active_low,
    input  logic [CNT_W-1:0] term,
    output logic             fp_act,
    output logic             lead,
    output logic             held,
    output logic             lockup
);
    localparam int HW = CNT_W + 1;

    logic          fp_last;
    logic [HW-1:0] hold_cnt;
    logic [HW-1:0] frame_len;

    assign fp_act    = fp_in ^ fp_active_low;        // R7 polarity
    assign lead      = fp_act & ~fp_last;
    assign held      = fp_act & fp_last;
    assign frame_len = {1'b0, term} + HW'(1);

    // Remember the previous normalised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_last <= 1'b0;
        else        fp_last <= fp_act;
    end

    // Count consecutive active samples, saturating at one frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_cnt <= '0;
        else if (!fp_act)           hold_cnt <= '0;
        else if (hold_cnt < frame_len) hold_cnt <= hold_cnt + HW'(1);
    end

    // Flag lock-up once the pulse outlasts a full frame (R6).
    always_ff @(posedge clk) begin
        if (!rst_n)                     lockup <= 1'b0;
        else if (!fp_act)               lockup <= 1'b0;
        else if (hold_cnt >= frame_len) lockup <= 1'b1;
    end

    assert_lock_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockup) |-> $past(fp_act));
    assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup && !fp_act) |=> !lockup);
endmodule

// File: rtl/fpt_channel_counter.sv
// Module: channel counter that free-runs from 0 to the terminal value.
// A leading edge forces it to 0, and a held pulse freezes it.
// Assumes: lead and held are never high together.
module fpt_channel_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead,
    input  logic             held,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_start,
    output logic             on_time
);
    assign on_time = (cnt == term);

    // Advance, wrap, realign or hold the channel count (R2, R3, R5).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            frame_start <= 1'b0;
        end else if (lead) begin
            cnt         <= '0;
            frame_start <= 1'b1;
        end else if (held) begin
            frame_start <= 1'b0;
        end else if (cnt >= term) begin
            cnt         <= '0;
            frame_start <= 1'b1;
        end else begin
            cnt         <= cnt + CNT_W'(1);
            frame_start <= 1'b0;
        end
    end

    assert_lead_held_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && held));
endmodule

// File: rtl/fpt_error_flag.sv
// Module: sticky framing-change flag with acquisition and a masked interrupt.
// Assumes: on_time reflects the count before the current edge.
module fpt_error_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lead,
    input  logic on_time,
    input  logic err_clr,
    input  logic err_mask,
    output logic err,
    output logic irq
);
    logic acquired;

    // Note that a first pulse has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    acquired <= 1'b0;
        else if (lead) acquired <= 1'b1;
    end

    // Set on a misplaced edge (R4); clear on request, set wins (R8).
    always_ff @(posedge clk) begin
        if (!rst_n)                           err <= 1'b0;
        else if (lead && acquired && !on_time) err <= 1'b1;
        else if (err_clr)                     err <= 1'b0;
    end

    assign irq = err & ~err_mask;              // R9

    assert_no_set_without_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead && !err) |=> !err);
    assert_first_edge_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lead && !acquired && !err) |=> !err);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !lead) |=> !err);
endmodule

// File: rtl/fpt_frame_tracker.sv
// Module: top of the frame pulse tracker. It joins the rate decode, the
// pulse monitor, the channel counter and the error flag.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module fpt_frame_tracker #(
    parameter int CNT_W     = 12,
    parameter int TERM_FAST = 2429,
    parameter int TERM_MID  = 2047,
    parameter int TERM_SLOW = 809
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_in,
    input  logic             fp_active_low,
    input  logic [1:0]       rate_sel,
    input  logic             err_clr,
    input  logic             err_mask,
    output logic [CNT_W-1:0] chan_cnt,
    output logic             frame_start,
    output logic             lockup,
    output logic             err_flag,
    output logic             irq
);
    logic [CNT_W-1:0] term;
    logic             fp_act;
    logic             lead;
    logic             held;
    logic             on_time;

    fpt_term_sel #(
        .CNT_W(CNT_W), .TERM_FAST(TERM_FAST),
        .TERM_MID(TERM_MID), .TERM_SLOW(TERM_SLOW)
    ) u_term (
        .rate_sel (rate_sel),
        .term     (term)
    );

    fpt_pulse_monitor #(.CNT_W(CNT_W)) u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp_in         (fp_in),
        .fp_active_low (fp_active_low),
        .term          (term),
        .fp_act        (fp_act),
        .lead          (lead),
        .held          (held),
        .lockup        (lockup)
    );

    fpt_channel_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .lead        (lead),
        .held        (held),
        .term        (term),
        .cnt         (chan_cnt),
        .frame_start (frame_start),
        .on_time     (on_time)
    );

    fpt_error_flag u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .lead     (lead),
        .on_time  (on_time),
        .err_clr  (err_clr),
        .err_mask (err_mask),
        .err      (err_flag),
        .irq      (irq)
    );

    assert_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> (chan_cnt == '0 && frame_start));
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_cnt == term && !fp_act) |=> (chan_cnt == '0 && frame_start));
    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(chan_cnt) && !frame_start));
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead && $stable(rate_sel) && chan_cnt <= term) |=> chan_cnt <= term);
endmodule

// File: tb/test_fpt_frame_tracker.sv
module test_fpt_frame_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp_in = 1'b0;
    logic        fp_active_low = 1'b0;
    logic [1:0]  rate_sel = 2'd2;
    logic        err_clr = 1'b0;
    logic        err_mask = 1'b0;
    logic [11:0] chan_cnt;
    logic        frame_start, lockup, err_flag, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpt_frame_tracker i_fpt_frame_tracker (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fp_active_low(fp_active_low),
        .rate_sel(rate_sel), .err_clr(err_clr), .err_mask(err_mask),
        .chan_cnt(chan_cnt), .frame_start(frame_start), .lockup(lockup),
        .err_flag(err_flag), .irq(irq)
    );

    // Table rows: rate code, pulse spacing in clocks, expected error flag.
    localparam int NV = 11;
    localparam int ROW_RATE [NV] = '{2, 2, 2, 2, 3, 1, 1, 0, 0, 0, 2};
    localparam int ROW_GAP  [NV] = '{810, 810, 500, 1620, 810, 2048, 2000,
                                     2430, 4860, 2431, 810};
    localparam int ROW_ERR  [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0};

    function automatic int flen(input int rate);
        return (rate == 0) ? 2430 : (rate == 1) ? 2048 : 810;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Drive one active sample and return just after the capturing edge.
    task automatic pulse();
        fp_in = ~fp_active_low;
        tick();
        fp_in = fp_active_low;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) tick();
        chk("R10 cnt", int'(chan_cnt), 0);
        chk("R10 frame_start", int'(frame_start), 0);
        chk("R10 lockup", int'(lockup), 0);
        chk("R10 err", int'(err_flag), 0);
        chk("R10 irq", int'(irq), 0);
        rst_n = 1'b1;

        // R4: the first pulse after reset acquires without error
        repeat (37) tick();
        pulse();
        chk("R3 acquire cnt", int'(chan_cnt), 0);
        chk("R4 first pulse no error", int'(err_flag), 0);

        // Table walk: spacing, free-run wraps, resync, error
        for (int r = 0; r < NV; r++) begin
            int fl;
            rate_sel = 2'(ROW_RATE[r]);
            fl = flen(ROW_RATE[r]);
            err_clr = 1'b1;
            for (int i = 1; i < ROW_GAP[r]; i++) begin
                tick();
                err_clr = 1'b0;
                if (i % fl == 0)
                    chk("R2 wrap strobe", int'(frame_start), 1);
            end
            chk("R1/R2 count before pulse", int'(chan_cnt), (ROW_GAP[r] - 1) % fl);
            pulse();
            chk("R3 resync cnt", int'(chan_cnt), 0);
            chk("R3 resync strobe", int'(frame_start), 1);
            chk("R4 error after row", int'(err_flag), ROW_ERR[r]);
        end

        // R5: held pulse stalls the counter
        rate_sel = 2'd2;
        repeat (20) tick();
        fp_in = 1'b1;
        tick();
        chk("R5 first sample cnt", int'(chan_cnt), 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R5 held cnt", int'(chan_cnt), 0);
            chk("R5 held strobe", int'(frame_start), 0);
        end
        fp_in = 1'b0;
        tick();
        chk("R5 resume cnt", int'(chan_cnt), 1);

        // R6: lock-up after more than one frame of active level
        repeat (10) tick();
        fp_in = 1'b1;
        repeat (810) tick();
        chk("R6 no lockup at one frame", int'(lockup), 0);
        chk("R5 long hold cnt", int'(chan_cnt), 0);
        tick();
        chk("R6 lockup raised", int'(lockup), 1);
        fp_in = 1'b0;
        tick();
        chk("R6 lockup released", int'(lockup), 0);
        chk("R5 count after release", int'(chan_cnt), 1);

        // R8: sticky flag; set wins over a simultaneous clear
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        chk("R8 cleared", int'(err_flag), 0);
        repeat (50) tick();
        err_clr = 1'b1;
        pulse();
        chk("R8 set wins over clear", int'(err_flag), 1);
        err_clr = 1'b0;
        repeat (5) tick();
        chk("R8 sticky", int'(err_flag), 1);

        // R9: interrupt masking
        err_mask = 1'b1;
        tick();
        chk("R9 masked irq", int'(irq), 0);
        err_mask = 1'b0;
        tick();
        chk("R9 unmasked irq", int'(irq), 1);
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        chk("R8 clear", int'(err_flag), 0);
        chk("R9 irq after clear", int'(irq), 0);

        // R7: active-low polarity
        fp_active_low = 1'b1;
        fp_in = 1'b1;
        repeat (30) tick();
        pulse();
        chk("R7 active-low resync", int'(chan_cnt), 0);
        tick();
        chk("R7 rising level ignored", int'(chan_cnt), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule